// File: doc/BRIEF.md
# Data-Strobe Line Codec

This block turns a stream of 32-bit words into a two-wire serial bit stream, and turns such a stream back into words. The transmit side accepts a word over a valid/ready handshake. It sends the word most significant bit first, one bit cell every `CELL_CYCLES` clocks. The data wire carries the plain bit level. The strobe wire flips only when a bit equals the bit before it. As a result, exactly one of the two wires moves in every cell, and the XOR of the two wires toggles once per bit.

A packet is a run of words, with the last one marked. After the last word, the transmitter brings both wires back to low. It lowers one wire per cell, so a packet always begins from a known low line. The line is half-duplex. Only one side drives at a time, so the receive pins are separate inputs.

The receive side oversamples the two wires with the system clock through a synchronizer. It takes one bit, equal to the data level, on every sample in which exactly one wire changed. After 32 bits it presents the word with a one-cycle valid pulse. A frame-start input discards any partial word. A sample in which both wires changed raises a one-cycle error pulse and adds no bit.

Top module: `ds_link`

## Requirements
- R1: While reset is high and in the cycle after it falls: both transmit wires are low, `tx_ready` is high, and `rx_valid` and `rx_err` are low.
- R2: In each bit cell the transmit data wire carries the bit's level (1 = high, 0 = low). Bits go out most significant bit first. Each cell lasts `CELL_CYCLES` clocks, and the wires change only at the first clock of a cell.
- R3: The strobe wire flips exactly when the current bit equals the previous bit, and holds otherwise. The previous bit is taken as 0 for the first bit of a packet and carries across words inside a packet.
- R4: The two transmit wires never change in the same clock.
- R5: After the word marked last, the data wire is lowered (if high) and then the strobe wire (if high), one per cell, before `tx_ready` returns. After a word not marked last, both wires hold their levels.
- R6: A word is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` is low from acceptance until the word, and any return to low, has been sent.
- R7: The receiver records one bit (the data level) for each sample in which exactly one wire changed. After 32 bits, `rx_word` holds them with the first received bit in bit 31, and `rx_valid` is high for one cycle.
- R8: `rx_sof` high for a cycle discards any partly received word, so the next 32 bits form a word.
- R9: A sample in which both wires changed gives a one-cycle `rx_err` pulse and records no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the receive oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_word | input | WORD_W | Word to send, MSB first |
| tx_last | input | 1 | Offered word ends the packet |
| tx_ds_data | output | 1 | Transmit data wire |
| tx_ds_strobe | output | 1 | Transmit strobe wire |
| rx_ds_data | input | 1 | Receive data wire (asynchronous) |
| rx_ds_strobe | input | 1 | Receive strobe wire (asynchronous) |
| rx_sof | input | 1 | Frame start: drop partial receive word |
| rx_word | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` is new |
| rx_err | output | 1 | One-cycle pulse: both wires changed in one sample |

## Verification
The bench builds the block with `WORD_W` = 32, `SYNC_STAGES` = 2 and `CELL_CYCLES` = 3.

A three-clock cell makes the cell counter wrap at a value that is not a power of two. It also gives the mid-cell clocks in which the wires must hold still. The two-stage synchronizer puts a real pipeline delay between a line transition and the decoded bit.

With the transmitter looped back to the receiver, all-ones, all-zeros, alternating and mixed words test the strobe rule, including the implied zero before a packet. Direct drive of the receive wires then produces partial words and simultaneous changes for the frame-start and error paths.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

    // Two-wire line state: level of the data wire and the strobe wire.
    typedef struct packed {
        logic data;
        logic strobe;
    } ds_pair_t;

    typedef enum logic [1:0] {
        ENC_IDLE = 2'd0,
        ENC_SEND = 2'd1,
        ENC_PARK = 2'd2
    } enc_state_e;

    // Next line state for one bit cell: data follows the bit,
    // strobe flips only when the bit repeats the previous one.
    function automatic ds_pair_t ds_next(ds_pair_t cur, logic bit_v);
        ds_pair_t nxt;
        nxt.data   = bit_v;
        nxt.strobe = (bit_v == cur.data) ? ~cur.strobe : cur.strobe;
        return nxt;
    endfunction

    // One step of returning the line to low: data first, then strobe.
    function automatic ds_pair_t ds_park(ds_pair_t cur);
        ds_pair_t nxt;
        nxt = cur;
        if (cur.data)
            nxt.data = 1'b0;
        else
            nxt.strobe = 1'b0;
        return nxt;
    endfunction

    function automatic logic ds_both_moved(ds_pair_t a, ds_pair_t b);
        return (a.data != b.data) && (a.strobe != b.strobe);
    endfunction

    function automatic logic ds_one_moved(ds_pair_t a, ds_pair_t b);
        return (a.data != b.data) ^ (a.strobe != b.strobe);
    endfunction

endpackage

// File: rtl/ds_sync.sv
module ds_sync
    import ds_link_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  ds_pair_t d_i,
    output ds_pair_t q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            ds_pair_t pipe [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign q_o = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ds_enc.sv
module ds_enc
    import ds_link_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CELL_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    output ds_pair_t          line_o
);

    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int CW = (CELL_CYCLES > 1) ? $clog2(CELL_CYCLES) : 1;
    localparam logic [BW-1:0] BIT_LAST  = BW'(WORD_W - 1);
    localparam logic [CW-1:0] CELL_LAST = CW'(CELL_CYCLES - 1);

    enc_state_e        state;
    ds_pair_t          line;
    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     cell_cnt;
    logic [BW-1:0]     bit_idx;
    logic              last_q;

    wire cell_start = (cell_cnt == '0);
    wire cell_end   = (cell_cnt == CELL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENC_IDLE;
            line     <= '0;
            shreg    <= '0;
            cell_cnt <= '0;
            bit_idx  <= '0;
            last_q   <= 1'b0;
        end else begin
            unique case (state)
                ENC_IDLE: begin
                    if (in_valid) begin
                        shreg    <= in_word;
                        last_q   <= in_last;
                        bit_idx  <= '0;
                        cell_cnt <= '0;
                        state    <= ENC_SEND;
                    end
                end
                ENC_SEND: begin
                    if (cell_start)
                        line <= ds_next(line, shreg[WORD_W-1]);
                    if (cell_end) begin
                        cell_cnt <= '0;
                        shreg    <= {shreg[WORD_W-2:0], 1'b0};
                        if (bit_idx == BIT_LAST)
                            state <= last_q ? ENC_PARK : ENC_IDLE;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cell_cnt <= cell_cnt + 1'b1;
                    end
                end
                ENC_PARK: begin
                    if (cell_start && line == '0) begin
                        state <= ENC_IDLE;
                    end else begin
                        if (cell_start)
                            line <= ds_park(line);
                        cell_cnt <= cell_end ? '0 : cell_cnt + 1'b1;
                    end
                end
                default: state <= ENC_IDLE;
            endcase
        end
    end

    assign in_ready = (state == ENC_IDLE);
    assign line_o   = line;

    // R4
    one_change_chk: assert property (@(posedge clk) disable iff (rst)
        !ds_both_moved(line, $past(line)));

    // R2
    cell_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cell_cnt) != '0) |-> (line == $past(line)));

    // R5
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENC_IDLE && $past(state) == ENC_PARK) |-> (line == '0));

endmodule

// File: rtl/ds_dec.sv
module ds_dec
    import ds_link_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ds_pair_t          line_i,
    input  logic              sof_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

    ds_pair_t          prev;
    logic [WORD_W-1:0] shreg;
    logic [BW-1:0]     bit_cnt;

    wire               one_move  = ds_one_moved(line_i, prev);
    wire               both_move = ds_both_moved(line_i, prev);
    wire [WORD_W-1:0]  shifted   = {shreg[WORD_W-2:0], line_i.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            shreg   <= '0;
            bit_cnt <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            prev    <= line_i;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (sof_i) begin
                bit_cnt <= '0;
            end else if (both_move) begin
                err_o <= 1'b1;
            end else if (one_move) begin
                shreg <= shifted;
                if (bit_cnt == BIT_LAST) begin
                    word_o  <= shifted;
                    valid_o <= 1'b1;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o);

    // R8
    sof_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> (bit_cnt == '0 && !valid_o));

endmodule

// File: rtl/ds_link.sv
module ds_link
    import ds_link_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CELL_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_last,
    output logic              tx_ds_data,
    output logic              tx_ds_strobe,
    input  logic              rx_ds_data,
    input  logic              rx_ds_strobe,
    input  logic              rx_sof,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_err
);

    ds_pair_t tx_line;
    ds_pair_t rx_raw;
    ds_pair_t rx_line;

    ds_enc #(
        .WORD_W      (WORD_W),
        .CELL_CYCLES (CELL_CYCLES)
    ) enc_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_word  (tx_word),
        .in_last  (tx_last),
        .line_o   (tx_line)
    );

    assign tx_ds_data   = tx_line.data;
    assign tx_ds_strobe = tx_line.strobe;

    assign rx_raw.data   = rx_ds_data;
    assign rx_raw.strobe = rx_ds_strobe;

    ds_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (rx_raw),
        .q_o (rx_line)
    );

    ds_dec #(
        .WORD_W (WORD_W)
    ) dec_i (
        .clk     (clk),
        .rst     (rst),
        .line_i  (rx_line),
        .sof_i   (rx_sof),
        .word_o  (rx_word),
        .valid_o (rx_valid),
        .err_o   (rx_err)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tx_ds_data && !tx_ds_strobe && tx_ready && !rx_valid && !rx_err));

endmodule

// File: tb/ds_link_tb_top.sv
`timescale 1ns/1ps
module ds_link_tb_top;

    localparam int W    = 32;
    localparam int CELL = 3;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [W-1:0]  tx_word = '0;
    logic          tx_last = 1'b0;
    logic          tx_ds_data, tx_ds_strobe;
    logic          rx_sof = 1'b0;
    logic [W-1:0]  rx_word;
    logic          rx_valid, rx_err;

    logic          inj_en = 1'b0;
    logic          inj_d = 1'b0;
    logic          inj_s = 1'b0;
    wire           rx_d = inj_en ? inj_d : tx_ds_data;
    wire           rx_s = inj_en ? inj_s : tx_ds_strobe;

    always #2.5 clk = ~clk;

    ds_link #(.WORD_W(W), .CELL_CYCLES(CELL), .SYNC_STAGES(SYNC)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_word      (tx_word),
        .tx_last      (tx_last),
        .tx_ds_data   (tx_ds_data),
        .tx_ds_strobe (tx_ds_strobe),
        .rx_ds_data   (rx_d),
        .rx_ds_strobe (rx_s),
        .rx_sof       (rx_sof),
        .rx_word      (rx_word),
        .rx_valid     (rx_valid),
        .rx_err       (rx_err)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Line monitor, sampled at the falling edge.
    logic       mon_d = 1'b0, mon_s = 1'b0;
    logic       ev_bit [256];
    logic       ev_rep [256];
    int         ev_n = 0;
    int         both_n = 0;
    logic [W-1:0] rx_words [16];
    int         rx_n = 0;
    int         err_n = 0;
    logic [W-1:0] pkt_w [8];

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_ds_data != mon_d && tx_ds_strobe != mon_s)
                both_n++;
            else if (tx_ds_data != mon_d || tx_ds_strobe != mon_s) begin
                if (ev_n < 256) begin
                    ev_bit[ev_n] = tx_ds_data;
                    ev_rep[ev_n] = (tx_ds_strobe != mon_s);
                end
                ev_n++;
            end
            if (rx_valid) begin
                if (rx_n < 16) rx_words[rx_n] = rx_word;
                rx_n++;
            end
            if (rx_err) err_n++;
        end
        mon_d = tx_ds_data;
        mon_s = tx_ds_strobe;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ev_n = 0; both_n = 0; rx_n = 0; err_n = 0;
    endtask

    task automatic pulse_sof();
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
    endtask

    task automatic offer(input logic [W-1:0] w, input logic last);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_word = w; tx_last = last;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R6 busy after accept", {31'b0, tx_ready}, 32'd0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        repeat (SYNC + 6) @(negedge clk);
    endtask

    // Compare monitored line events with the bits of pkt_w[0..n-1].
    task automatic check_line(input int n, input string tag);
        int   bad_bit = 0;
        int   bad_rep = 0;
        logic prev = 1'b0;
        chk({"R2 event count ", tag}, (ev_n >= 32*n) ? 32'd1 : 32'd0, 32'd1);
        for (int i = 0; i < 32*n && i < 256; i++) begin
            logic b;
            b = pkt_w[i/32][31 - (i%32)];
            if (ev_bit[i] !== b) bad_bit++;
            if (ev_rep[i] !== (b == prev)) bad_rep++;
            prev = b;
        end
        chk({"R2 bit order ", tag}, bad_bit, 0);
        chk({"R3 strobe rule ", tag}, bad_rep, 0);
        chk({"R4 no double change ", tag}, both_n, 0);
    endtask

    task automatic check_rx(input int n, input string tag);
        chk({"R7 word count ", tag}, rx_n, n);
        for (int i = 0; i < n && i < 16; i++)
            chk({"R7 word value ", tag}, rx_words[i], pkt_w[i]);
    endtask

    task automatic t_reset();
        chk("R1 data low", {31'b0, tx_ds_data}, 0);
        chk("R1 strobe low", {31'b0, tx_ds_strobe}, 0);
        chk("R1 ready high", {31'b0, tx_ready}, 1);
        chk("R1 rx quiet", {30'b0, rx_valid, rx_err}, 0);
    endtask

    task automatic t_packet(input int n, input string tag);
        pulse_sof();
        repeat (2) @(negedge clk);
        clear_mon();
        for (int i = 0; i < n; i++) offer(pkt_w[i], i == n-1);
        wait_idle();
        check_line(n, tag);
        check_rx(n, tag);
        chk({"R5 parked low ", tag}, {30'b0, tx_ds_data, tx_ds_strobe}, 0);
    endtask

    task automatic t_hold();
        pkt_w[0] = 32'h0000_0001;
        pkt_w[1] = 32'h8000_0000;
        pulse_sof();
        repeat (2) @(negedge clk);
        clear_mon();
        offer(pkt_w[0], 1'b0);
        wait_idle();
        chk("R5 data holds after open word", {31'b0, tx_ds_data}, 1);
        repeat (5) @(negedge clk);
        chk("R5 no park after open word", ev_n, 32);
        offer(pkt_w[1], 1'b1);
        wait_idle();
        check_line(2, "hold");
        check_rx(2, "hold");
    endtask

    task automatic t_sof();
        pulse_sof();
        @(negedge clk); inj_en = 1'b1; inj_d = 1'b0; inj_s = 1'b0;
        repeat (4) @(negedge clk);
        clear_mon();
        // six single-wire steps, ending with both wires low
        for (int k = 0; k < 6; k++) begin
            if (k % 4 < 2) inj_d = ~inj_d; else inj_s = ~inj_s;
            repeat (3) @(negedge clk);
        end
        repeat (SYNC + 3) @(negedge clk);
        inj_en = 1'b0;
        pulse_sof();
        pkt_w[0] = 32'hC0DE_5A17;
        offer(pkt_w[0], 1'b1);
        wait_idle();
        check_rx(1, "after sof");
        chk("R8 no stray word", rx_n, 1);
    endtask

    task automatic t_err();
        pulse_sof();
        @(negedge clk); inj_en = 1'b1; inj_d = 1'b0; inj_s = 1'b0;
        repeat (4) @(negedge clk);
        clear_mon();
        inj_d = 1'b1; inj_s = 1'b1;
        repeat (SYNC + 4) @(negedge clk);
        chk("R9 first error pulse", err_n, 1);
        inj_d = 1'b0; inj_s = 1'b0;
        repeat (SYNC + 4) @(negedge clk);
        chk("R9 second error pulse", err_n, 2);
        chk("R9 no word from errors", rx_n, 0);
        inj_en = 1'b0;
        // no frame start: a correct word proves no bit was recorded
        pkt_w[0] = 32'h1234_ABCD;
        offer(pkt_w[0], 1'b1);
        wait_idle();
        check_rx(1, "after error");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        pkt_w[0] = 32'hA5C3_0F81;
        t_packet(1, "mixed");
        pkt_w[0] = 32'hFFFF_FFFF;
        t_packet(1, "ones");
        pkt_w[0] = 32'h0000_0000;
        t_packet(1, "zeros");
        pkt_w[0] = 32'h5555_5555;
        t_packet(1, "alternating");
        pkt_w[0] = 32'h8000_0001;
        pkt_w[1] = 32'h7FFF_FFFE;
        pkt_w[2] = 32'hDEAD_BEEF;
        t_packet(3, "three words");
        t_hold();
        t_sof();
        t_err();
        finish_run();
    end

endmodule